// File: doc/BRIEF.md
# Token Slice Arbiter

This block hands one shared execution resource to one of `NREQ` requesters. Each requester owns a token account. A token stands for one time unit of execution, and a time unit is marked by a one-cycle `tick` pulse. Each account earns one token every `period` ticks, up to a cap. A requester may win the resource only when it is asking for it and holds at least its admission threshold of tokens. Once it wins, it keeps the grant and pays one token per tick. It gives the grant up when its account reaches zero or when it withdraws its request.

When the resource is free, the next owner is the first eligible requester after the previous owner, in round-robin order. The threshold and the cap are separate per-requester settings. Setting them equal gives every requester a slice of fixed length, so the rotation time is steady at about `NREQ` times that value. With the reset settings (threshold 50, cap 100, one token per 31 ticks, which is about 32 tokens per second at a 1 ms tick), a slice lasts from 50 to 100 units.

Settings are written through a simple load port, one requester at a time, and only while no grant is held.

Top module: `token_slice_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant` is all zero, `grant_vld` is 0 and `owner` is 0. Every account holds 0 tokens. The round-robin pointer starts at requester `NREQ-1`, so requester 0 is the first candidate.
- R2: An account whose `period` P is nonzero gains one token on every P-th tick counted from its last settings write. With P = 0 it gains none. An account never exceeds its cap: a refill at the cap is discarded. After reset, every account has threshold 50, cap 100 and period 31.
- R3: Requester i is eligible when `req[i]` is 1, its token count is nonzero and its count is at least its threshold. Tokens credited at a clock edge can produce a grant at the next edge.
- R4: When no grant is held, the next clock edge grants the first eligible requester found by searching from the index after the last owner, wrapping around. The grant stays with that owner until R5 or R6 releases it.
- R5: On each tick the owner's account loses one token. The grant is released at the same edge at which the count reaches zero. With ticks in every cycle and no refill, a slice therefore lasts exactly as many cycles as the tokens held when it was granted.
- R6: If the owner's request is 0 in a cycle, the grant is released at the next edge. The unspent tokens stay in its account.
- R7: When a refill and a consumption fall on the same tick for the owner, the refill is added first, the result is capped, and then one token is taken (new count = min(count+1, cap) − 1).
- R8: A write to the settings (`cfg_we` with `cfg_sel`, `cfg_period`, `cfg_min`, `cfg_max`) is ignored when `grant_vld` is 1 or when `cfg_min` > `cfg_max`. An accepted write replaces all three settings, restarts the refill count, and lowers the token count to the new cap if it was above it.
- R9: `grant` is one-hot or zero. Bit i set means requester i owns the resource, `grant_vld` is 1 exactly when a bit is set, and `owner` gives that index (0 when no grant is held).
- R10: If no requester is eligible while the resource is free, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse marking a time unit |
| req | input | NREQ | Request from each requester |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | IDX_W | Requester whose settings are written |
| cfg_period | input | PER_W | Ticks per refill token, 0 disables refill |
| cfg_min | input | TOK_W | Admission threshold in tokens |
| cfg_max | input | TOK_W | Token cap |
| grant | output | NREQ | One-hot grant |
| grant_vld | output | 1 | A grant is held |
| owner | output | IDX_W | Index of the current owner |

## Verification
A token count that drifted by even one would show as a slice that is one cycle too long or too short. It would also show as a grant that arrives a cycle early or late after a fill, and it would appear in the first slice after the fault. A corrupted round-robin pointer would show as the wrong `owner` at the next hand-over. A settings write that wrongly got through while a grant was held, or with threshold above cap, would change the length of the very next slice. The bench therefore measures slice lengths, hand-over order and grant latency, and it tracks every output cycle by cycle against an arithmetic model through long mixed runs of ticks, requests and writes.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    typedef enum logic {
        OWN_IDLE = 1'b0,
        OWN_HELD = 1'b1
    } own_state_e;

    localparam int TSA_TOK_W   = 8;
    localparam int TSA_PER_W   = 6;
    localparam int TSA_DEF_MIN = 50;
    localparam int TSA_DEF_MAX = 100;
    localparam int TSA_DEF_PER = 31;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsa_bucket.sv
module tsa_bucket #(
    parameter int TOK_W   = tsa_pkg::TSA_TOK_W,
    parameter int PER_W   = tsa_pkg::TSA_PER_W,
    parameter int DEF_MIN = tsa_pkg::TSA_DEF_MIN,
    parameter int DEF_MAX = tsa_pkg::TSA_DEF_MAX,
    parameter int DEF_PER = tsa_pkg::TSA_DEF_PER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  logic             cfg_load,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [TOK_W-1:0] cfg_min,
    input  logic [TOK_W-1:0] cfg_max,
    input  logic             is_owner,
    output logic             eligible,
    output logic             drained
);

    logic [TOK_W-1:0] tok_q, min_q, max_q;
    logic [TOK_W-1:0] filled, spent, tok_d;
    logic [PER_W-1:0] per_q, cnt_q;
    logic             refill_hit;
    logic             use_tok;

    assign refill_hit = tick && (per_q != '0) && (cnt_q == per_q - 1'b1);

    // refill first, cap, then consume (R7)
    always_comb begin
        filled = tok_q;
        if (refill_hit && (tok_q < max_q)) begin
            filled = tok_q + 1'b1;
        end
        use_tok = tick && is_owner && (filled != '0);
        spent   = use_tok ? (filled - 1'b1) : filled;
        tok_d   = spent;
        if (cfg_load && (spent > cfg_max)) begin
            tok_d = cfg_max;
        end
    end

    assign drained  = tick && is_owner && (spent == '0);
    assign eligible = req && (tok_q != '0) && (tok_q >= min_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= '0;
            cnt_q <= '0;
            min_q <= TOK_W'(DEF_MIN);
            max_q <= TOK_W'(DEF_MAX);
            per_q <= PER_W'(DEF_PER);
        end else begin
            tok_q <= tok_d;
            if (cfg_load) begin
                per_q <= cfg_period;
                min_q <= cfg_min;
                max_q <= cfg_max;
                cnt_q <= '0;
            end else if (tick && (per_q != '0)) begin
                cnt_q <= refill_hit ? '0 : (cnt_q + 1'b1);
            end
        end
    end

    // R2: the account never holds more than its cap
    a_r2_under_cap: assert property (@(posedge clk) disable iff (rst)
        tok_q <= max_q);

    // R2: at most one token is gained per edge
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !cfg_load) |=>
            ({1'b0, tok_q} <= ({1'b0, $past(tok_q)} + 1'b1)));

    // R5: without a tick or a write the account does not move
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cfg_load) |=> $stable(tok_q));

endmodule

// File: rtl/tsa_rr_pick.sv
module tsa_rr_pick #(
    parameter int NREQ  = 4,
    parameter int IDX_W = tsa_pkg::idx_width(NREQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  elig,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NREQ; k++) begin
            int c;
            c = (int'(last) + k) % NREQ;
            if (!found && elig[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end

    // R4: a picked index is always an eligible one
    a_r4_pick_eligible: assert property (@(posedge clk) disable iff (rst)
        found |-> elig[pick]);

    // R10: nothing found only when nobody is eligible
    a_r10_none_found: assert property (@(posedge clk) disable iff (rst)
        !found |-> (elig == '0));

endmodule

// File: rtl/tsa_owner.sv
module tsa_owner #(
    parameter int NREQ  = 4,
    parameter int IDX_W = tsa_pkg::idx_width(NREQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             found,
    input  logic [IDX_W-1:0] pick,
    input  logic             req_own,
    input  logic             drain_own,
    output logic             held,
    output logic [IDX_W-1:0] own_idx,
    output logic [IDX_W-1:0] last_idx
);

    import tsa_pkg::*;

    own_state_e       state_q;
    logic [IDX_W-1:0] idx_q, last_q;
    logic             release_now;

    assign release_now = !req_own || drain_own;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OWN_IDLE;
            idx_q   <= '0;
            last_q  <= IDX_W'(NREQ - 1);
        end else begin
            case (state_q)
                OWN_HELD: begin
                    if (release_now) begin
                        state_q <= OWN_IDLE;
                    end
                end
                default: begin
                    if (found) begin
                        state_q <= OWN_HELD;
                        idx_q   <= pick;
                        last_q  <= pick;
                    end
                end
            endcase
        end
    end

    assign held     = (state_q == OWN_HELD);
    assign own_idx  = idx_q;
    assign last_idx = last_q;

    // R6: withdrawn request frees the resource at the next edge
    a_r6_drop_release: assert property (@(posedge clk) disable iff (rst)
        (held && !req_own) |=> !held);

    // R5: an exhausted account frees the resource at the next edge
    a_r5_drain_release: assert property (@(posedge clk) disable iff (rst)
        (held && drain_own) |=> !held);

    // R4: the owner keeps the grant while it still asks and has tokens
    a_r4_keep_owner: assert property (@(posedge clk) disable iff (rst)
        (held && req_own && !drain_own) |=> (held && $stable(idx_q)));

endmodule

// File: rtl/token_slice_arbiter.sv
module token_slice_arbiter #(
    parameter int NREQ    = 4,
    parameter int TOK_W   = tsa_pkg::TSA_TOK_W,
    parameter int PER_W   = tsa_pkg::TSA_PER_W,
    parameter int DEF_MIN = tsa_pkg::TSA_DEF_MIN,
    parameter int DEF_MAX = tsa_pkg::TSA_DEF_MAX,
    parameter int DEF_PER = tsa_pkg::TSA_DEF_PER,
    localparam int IDX_W  = tsa_pkg::idx_width(NREQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [NREQ-1:0]  req,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [TOK_W-1:0] cfg_min,
    input  logic [TOK_W-1:0] cfg_max,
    output logic [NREQ-1:0]  grant,
    output logic             grant_vld,
    output logic [IDX_W-1:0] owner
);

    logic [NREQ-1:0]  elig, drain, is_own, load;
    logic             found, held, cfg_ok;
    logic [IDX_W-1:0] pick, own_idx, last_idx;

    // R8: settings accepted only while free and with threshold <= cap
    assign cfg_ok = cfg_we && !held && (cfg_min <= cfg_max);

    for (genvar i = 0; i < NREQ; i++) begin : g_acct
        assign is_own[i] = held && (own_idx == IDX_W'(i));
        assign load[i]   = cfg_ok && (cfg_sel == IDX_W'(i));

        tsa_bucket #(
            .TOK_W  (TOK_W),
            .PER_W  (PER_W),
            .DEF_MIN(DEF_MIN),
            .DEF_MAX(DEF_MAX),
            .DEF_PER(DEF_PER)
        ) u_bucket (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .req       (req[i]),
            .cfg_load  (load[i]),
            .cfg_period(cfg_period),
            .cfg_min   (cfg_min),
            .cfg_max   (cfg_max),
            .is_owner  (is_own[i]),
            .eligible  (elig[i]),
            .drained   (drain[i])
        );
    end

    tsa_rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .last (last_idx),
        .found(found),
        .pick (pick)
    );

    tsa_owner #(.NREQ(NREQ), .IDX_W(IDX_W)) u_owner (
        .clk      (clk),
        .rst      (rst),
        .found    (found),
        .pick     (pick),
        .req_own  (req[own_idx]),
        .drain_own(drain[own_idx]),
        .held     (held),
        .own_idx  (own_idx),
        .last_idx (last_idx)
    );

    assign grant     = is_own;
    assign grant_vld = held;
    assign owner     = held ? own_idx : '0;

    // R9: at most one requester holds the resource
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R9: the reported index matches the asserted grant bit
    a_r9_index_match: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> grant[owner]);

    // R3: a new grant only goes to a requester that was eligible
    a_r3_new_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        (!held && found) |=> (held && $past(elig[pick])));

endmodule

// File: tb/token_slice_arbiter_tb.sv
module token_slice_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int TW    = 8;
    localparam int PW    = 6;
    localparam int IW    = 2;
    localparam int WATCH = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [N-1:0]  req = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_sel = '0;
    logic [PW-1:0] cfg_period = '0;
    logic [TW-1:0] cfg_min = '0;
    logic [TW-1:0] cfg_max = '0;
    logic [N-1:0]  grant;
    logic          grant_vld;
    logic [IW-1:0] owner;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    token_slice_arbiter #(.NREQ(N), .TOK_W(TW), .PER_W(PW)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .req(req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_period(cfg_period),
        .cfg_min(cfg_min), .cfg_max(cfg_max),
        .grant(grant), .grant_vld(grant_vld), .owner(owner)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // arithmetic reference of the accounts and the owner
    int m_tok[N], m_cnt[N], m_per[N], m_min[N], m_max[N];
    int m_vld, m_idx, m_last;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_tok[i] = 0; m_cnt[i] = 0;
                m_per[i] = 31; m_min[i] = 50; m_max[i] = 100;
            end
            m_vld = 0; m_idx = 0; m_last = N - 1;
        end else begin
            int fnd, pk, drn, acc, rel;
            int nt[N];
            fnd = 0; pk = 0; drn = 0;
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (m_last + k) % N;
                if (fnd == 0 && req[c] && m_tok[c] != 0 && m_tok[c] >= m_min[c]) begin
                    fnd = 1; pk = c;
                end
            end
            acc = (cfg_we && !m_vld && cfg_min <= cfg_max) ? 1 : 0;
            for (int i = 0; i < N; i++) begin
                int f;
                f = m_tok[i];
                if (tick && m_per[i] != 0 && m_cnt[i] == m_per[i] - 1 && f < m_max[i]) f = f + 1;
                if (tick && m_vld && m_idx == i && f != 0) begin
                    f = f - 1;
                    if (f == 0) drn = 1;
                end
                nt[i] = f;
                if (tick && m_per[i] != 0)
                    m_cnt[i] = (m_cnt[i] == m_per[i] - 1) ? 0 : m_cnt[i] + 1;
            end
            if (acc) begin
                int s;
                s = int'(cfg_sel);
                if (nt[s] > int'(cfg_max)) nt[s] = int'(cfg_max);
                m_per[s] = int'(cfg_period); m_min[s] = int'(cfg_min);
                m_max[s] = int'(cfg_max); m_cnt[s] = 0;
            end
            for (int i = 0; i < N; i++) m_tok[i] = nt[i];
            rel = (!req[m_idx] || drn) ? 1 : 0;
            if (m_vld) begin
                if (rel) m_vld = 0;
            end else if (fnd) begin
                m_vld = 1; m_idx = pk; m_last = pk;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model (R9 and all others)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int eg;
            eg = m_vld ? (1 << m_idx) : 0;
            chk(int'(grant) == eg, "R9 grant vs model", int'(grant), eg);
            chk(int'(grant_vld) == m_vld, "R9 grant_vld vs model", int'(grant_vld), m_vld);
            chk(int'(owner) == (m_vld ? m_idx : 0), "R9 owner vs model",
                int'(owner), m_vld ? m_idx : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCH && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCH);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; tick = 0; req = '0; cfg_we = 0;
        step(); step();
        rst = 0;
    endtask

    task automatic write_cfg(input int s, input int p, input int mn, input int mx);
        cfg_we = 1; cfg_sel = IW'(s); cfg_period = PW'(p);
        cfg_min = TW'(mn); cfg_max = TW'(mx);
        step();
        cfg_we = 0;
    endtask

    task automatic ticks(input int n);
        tick = 1;
        for (int i = 0; i < n; i++) step();
        tick = 0;
    endtask

    task automatic run_len(output int len);
        int guard;
        guard = 0;
        tick = 1;
        while (!grant_vld && guard < 50) begin step(); guard++; end
        len = 0;
        while (grant_vld && len < 300) begin len++; step(); end
        tick = 0;
    endtask

    initial begin
        int n, len;
        int ro[8], rl[8];
        int nr, cur, cl;

        // R1: reset state
        do_reset();
        chk(grant == '0 && !grant_vld && owner == '0, "R1 reset outputs",
            int'(grant), 0);

        // R2 defaults: 50 tokens at one per 31 ticks, grant next edge
        req = 4'b0001; tick = 1; n = 0;
        while (!grant_vld && n < 3000) begin step(); n++; end
        chk(n == 1551, "R2 default fill latency", n, 1551);
        chk(owner == 0 && grant == 4'b0001, "R3 default owner", int'(owner), 0);

        // R3: threshold 3, cap 6, period 2
        do_reset();
        write_cfg(0, 2, 3, 6);
        req = 4'b0001; tick = 1; n = 0;
        while (!grant_vld && n < 100) begin step(); n++; end
        chk(n == 7, "R3 threshold latency", n, 7);
        tick = 0; req = '0; step();

        // R2/R4/R5/R10: fixed slices, rotation skips non-requester 2
        do_reset();
        write_cfg(0, 1, 3, 3); write_cfg(1, 1, 5, 5);
        write_cfg(2, 1, 2, 2); write_cfg(3, 1, 4, 4);
        ticks(12);
        write_cfg(0, 0, 3, 3); write_cfg(1, 0, 5, 5);
        write_cfg(2, 0, 2, 2); write_cfg(3, 0, 4, 4);
        req = 4'b1011; tick = 1;
        nr = 0; cur = -1; cl = 0;
        for (int c = 0; c < 40; c++) begin
            if (grant_vld) begin
                if (cur == int'(owner)) cl++;
                else begin
                    if (cur >= 0 && nr < 8) begin ro[nr] = cur; rl[nr] = cl; nr++; end
                    cur = int'(owner); cl = 1;
                end
            end else if (cur >= 0) begin
                if (nr < 8) begin ro[nr] = cur; rl[nr] = cl; nr++; end
                cur = -1; cl = 0;
            end
            step();
        end
        chk(nr == 3, "R4 slice count", nr, 3);
        chk(ro[0] == 0 && rl[0] == 3, "R5 slice 0", rl[0], 3);
        chk(ro[1] == 1 && rl[1] == 5, "R4 order then R2 cap slice 1", ro[1] * 100 + rl[1], 105);
        chk(ro[2] == 3 && rl[2] == 4, "R4 skip ineligible slice 3", ro[2] * 100 + rl[2], 304);
        chk(!grant_vld, "R10 no grant when drained", int'(grant_vld), 0);
        tick = 0; req = '0; step();

        // R6: drop request mid-slice, keep remaining tokens
        do_reset();
        write_cfg(0, 1, 1, 8); ticks(10); write_cfg(0, 0, 1, 8);
        req = 4'b0001; tick = 1; n = 0;
        while (!grant_vld && n < 10) begin step(); n++; end
        step(); step(); step();
        tick = 0; req = '0; step();
        chk(!grant_vld, "R6 release on drop", int'(grant_vld), 0);
        req = 4'b0001; run_len(len);
        chk(len == 5, "R6 leftover tokens", len, 5);
        req = '0; step();

        // R8: write during grant ignored
        do_reset();
        write_cfg(0, 1, 6, 6); ticks(8); write_cfg(0, 0, 6, 6);
        req = 4'b0001; tick = 1; n = 0;
        while (!grant_vld && n < 10) begin step(); n++; end
        len = 0;
        while (grant_vld && len < 50) begin
            if (len == 0) begin
                cfg_we = 1; cfg_sel = 0; cfg_period = 0; cfg_min = 1; cfg_max = 1;
            end else cfg_we = 0;
            len++; step();
        end
        cfg_we = 0; tick = 0;
        chk(len == 6, "R8 write while held ignored", len, 6);
        req = '0; step();

        // R8: threshold above cap rejected
        do_reset();
        write_cfg(0, 1, 4, 4); ticks(6); write_cfg(0, 0, 4, 4);
        write_cfg(0, 0, 6, 2);
        req = 4'b0001; run_len(len);
        chk(len == 4, "R8 min>max ignored", len, 4);
        req = '0; step();

        // R8: accepted write lowers tokens to new cap
        do_reset();
        write_cfg(0, 1, 4, 4); ticks(6); write_cfg(0, 0, 1, 2);
        req = 4'b0001; run_len(len);
        chk(len == 2, "R8 cap on write", len, 2);
        req = '0; step();

        // R7: refill then cap then consume keeps owner at cap-1
        do_reset();
        write_cfg(0, 1, 3, 3); ticks(5);
        req = 4'b0001; tick = 1; n = 0;
        while (!grant_vld && n < 10) begin step(); n++; end
        for (int c = 0; c < 20; c++) step();
        chk(grant_vld, "R7 owner sustained by refill", int'(grant_vld), 1);
        tick = 0; req = '0; step();
        write_cfg(0, 0, 1, 3);
        req = 4'b0001; run_len(len);
        chk(len == 2, "R7 refill-cap-consume order", len, 2);
        req = '0; step();

        // R10: requests with empty accounts get nothing
        do_reset();
        write_cfg(1, 0, 0, 5);
        req = 4'b0010; ticks(10);
        chk(!grant_vld, "R10 zero tokens no grant", int'(grant_vld), 0);
        req = '0;

        // mixed sweep against the model (R2..R9)
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            req  = N'($urandom_range(0, 15));
            tick = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 15) == 0) begin
                cfg_we = 1; cfg_sel = IW'($urandom_range(0, 3));
                cfg_period = PW'($urandom_range(0, 3));
                cfg_min = TW'($urandom_range(0, 7));
                cfg_max = TW'($urandom_range(0, 7));
            end else cfg_we = 0;
            step();
        end
        cfg_we = 0; tick = 0; req = '0;
        step();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule